// File: doc/BRIEF.md
# Bit-Banged Serial EEPROM Responder

This block answers a host that drives a two-wire serial bus in software, one pin change at a time. The host presents a new (clock, data) pair together with a one-cycle `step_i` strobe. The block compares that pair with the levels it stored at the previous step. From the comparison it finds start and stop conditions and clock rising edges. It then runs a small framing engine that works like a simplified serial EEPROM. A start opens a command byte. After the command byte an acknowledge slot follows, then a word-address byte, then a second acknowledge slot. The byte at that address is then fetched from an internal byte array.

When the command byte ends in a 1 (read), the block shifts the byte it fetched at the end of the previous transaction onto the data line during the address phase, MSB first. A host therefore reads a byte in two transactions. The first places the address. The second, a read command, clocks the fetched byte out while it supplies the next address. The data line the host observes (`sda_o`) is the level stored at the last step. It is the host's own level unless the block forced it low for an acknowledge or drove a read-data bit. Writing received data into the array is not part of this block. The array contents come from a separate load port.

The sequencer has three states. `PH_IDLE` waits for a start. `PH_CMD` collects the command byte. `PH_ADDR` collects the address byte. The pending-acknowledge flag is kept apart from the state and can be set in any of the three. The transitions are:
- start (from any state) → `PH_CMD`
- eighth command bit: `PH_CMD` → `PH_ADDR`, acknowledge set
- eighth address bit: `PH_ADDR` → `PH_IDLE`, acknowledge set and data register loaded

Top module: `sbe_eeprom_responder`

## Requirements
- R1: After reset `sda_o` is 1, the state is `PH_IDLE` with no acknowledge pending, and the stored clock level is 1.
- R2: A step with the clock high at both the previous and the present step and the data line falling from 1 to 0 is a start. It enters `PH_CMD` at bit 0 and clears the read flag, and leaves a pending acknowledge pending. A step with the clock high at both steps and the data line rising is a stop, and it changes neither the state nor the bit count.
- R3: In `PH_IDLE` with no acknowledge pending, every step other than a start captures nothing and changes no register except the stored line levels.
- R4: In `PH_CMD` each captured bit enters the command MSB first. The eighth bit (command bit 0) selects read when it is 1 and write when it is 0. After the eighth bit the state is `PH_ADDR` and an acknowledge is pending.
- R5: The first clock rise while an acknowledge is pending forces `sda_o` to 0, clears the pending flag, and captures no bit.
- R6: In `PH_ADDR` each captured bit enters the address MSB first. In read mode, each capturing rise sets `sda_o` to the MSB of the data register, and the register then shifts left by one. In write mode `sda_o` follows the host.
- R7: On the eighth address bit the data register is loaded from the array at the newly completed address. An acknowledge becomes pending and the state returns to `PH_IDLE`.
- R8: A clock rise whose data level differs from the stored data level captures no bit and does not advance the bit count.
- R9: `sda_o` equals the host's data level of the last step, except after a step where R5 or R6 (read mode) drives it.
- R10: In a cycle without `step_i`, neither the stored line levels nor the state, flags or registers change.
- R11: While `load_en_i` is high, the byte `load_data_i` is written into array location `load_addr_i` at the clock edge. The array has 2^ADDR_W bytes: 256 by default, or 128 with ADDR_W = 7, in which case the low ADDR_W bits of the address index it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | Strobe: a new bus sample is present |
| scl_i | input | 1 | Host clock-line level for this step |
| sda_i | input | 1 | Host data-line level for this step |
| load_en_i | input | 1 | Array load strobe |
| load_addr_i | input | ADDR_W | Array load address |
| load_data_i | input | 8 | Array load byte |
| sda_o | output | 1 | Stored data-line level seen by the host |

## Verification
The assertions assume that the host changes the line levels only through `step_i`. They also assume that each acknowledge or read-data slot is clocked by a separate rise, preceded by a step with the clock low. The bench's line tasks always move the clock low before a rise and return it high in its own step. Start and stop conditions are formed only by changing the data level while the clock stays high. The only deliberate rule breaks are single steps: a data change on a rising step, and pin wiggles with the strobe held low.

// File: rtl/sbe_pkg.sv
`timescale 1ns/1ps
package sbe_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CMD  = 2'd1,
        PH_ADDR = 2'd2
    } phase_e;
endpackage

// File: rtl/sbe_line_classifier.sv
`timescale 1ns/1ps
// Compares the stored line levels with the new sample and names the event.
module sbe_line_classifier (
    input  logic scl_prev,
    input  logic sda_prev,
    input  logic scl_now,
    input  logic sda_now,
    output logic ev_start,
    output logic ev_stop,
    output logic ev_rise,
    output logic ev_steady
);
    logic held_high;
    logic data_moved;

    assign held_high  = scl_prev & scl_now;
    assign data_moved = sda_prev ^ sda_now;
    assign ev_start   = held_high & data_moved & ~sda_now;
    assign ev_stop    = held_high & data_moved & sda_now;
    assign ev_rise    = ~scl_prev & scl_now;
    assign ev_steady  = ~data_moved;
endmodule

// File: rtl/sbe_store.sv
`timescale 1ns/1ps
// Byte array with a load port and an asynchronous read port.
module sbe_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/sbe_sequencer.sv
`timescale 1ns/1ps
// Framing engine: phase, bit count, acknowledge flag, shift registers,
// and the stored line levels.
module sbe_sequencer
    import sbe_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_rise,
    input  logic              ev_steady,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              scl_q_o,
    output logic              sda_q_o,
    output phase_e            phase_o,
    output logic              ack_o
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

    phase_e            phase_q, phase_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic              ack_q, ack_n;
    logic              rd_mode_q, rd_mode_n;
    logic [DATA_W-1:0] addr_q, addr_n;
    logic [DATA_W-1:0] data_q, data_n;
    logic              scl_q, scl_n;
    logic              sda_q, sda_n;
    logic [DATA_W-1:0] addr_shift;
    logic              cnt_last;

    assign addr_shift = {addr_q[DATA_W-2:0], sda_i};
    assign rd_addr    = addr_shift[ADDR_W-1:0];
    assign cnt_last   = (cnt_q == CNT_LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            cnt_q     <= '0;
            ack_q     <= 1'b0;
            rd_mode_q <= 1'b0;
            addr_q    <= '0;
            data_q    <= '0;
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
        end else begin
            phase_q   <= phase_n;
            cnt_q     <= cnt_n;
            ack_q     <= ack_n;
            rd_mode_q <= rd_mode_n;
            addr_q    <= addr_n;
            data_q    <= data_n;
            scl_q     <= scl_n;
            sda_q     <= sda_n;
        end
    end

    // Next-state and driven-line logic
    always_comb begin
        phase_n   = phase_q;
        cnt_n     = cnt_q;
        ack_n     = ack_q;
        rd_mode_n = rd_mode_q;
        addr_n    = addr_q;
        data_n    = data_q;
        scl_n     = scl_q;
        sda_n     = sda_q;
        if (step_i) begin
            scl_n = scl_i;
            sda_n = sda_i;
            if (ev_start) begin
                phase_n   = PH_CMD;
                cnt_n     = '0;
                rd_mode_n = 1'b0;
            end else if (ev_stop) begin
                phase_n = phase_q;
            end else if ((phase_q == PH_IDLE) && !ack_q) begin
                phase_n = PH_IDLE;
            end else if (ev_rise) begin
                if (ack_q) begin
                    sda_n = 1'b0;
                    ack_n = 1'b0;
                end else if (ev_steady) begin
                    unique case (phase_q)
                        PH_CMD: begin
                            rd_mode_n = sda_i;
                            cnt_n     = cnt_q + 1'b1;
                            if (cnt_last) begin
                                phase_n = PH_ADDR;
                                cnt_n   = '0;
                                ack_n   = 1'b1;
                            end
                        end
                        PH_ADDR: begin
                            if (rd_mode_q) begin
                                sda_n = data_q[DATA_W-1];
                            end
                            addr_n = addr_shift;
                            data_n = {data_q[DATA_W-2:0], 1'b0};
                            cnt_n  = cnt_q + 1'b1;
                            if (cnt_last) begin
                                data_n  = rd_data;
                                ack_n   = 1'b1;
                                phase_n = PH_IDLE;
                                cnt_n   = '0;
                            end
                        end
                        default: begin
                            phase_n = PH_IDLE;
                        end
                    endcase
                end
            end
        end
    end

    assign scl_q_o = scl_q;
    assign sda_q_o = sda_q;
    assign phase_o = phase_q;
    assign ack_o   = ack_q;
endmodule

// File: rtl/sbe_eeprom_responder.sv
`timescale 1ns/1ps
module sbe_eeprom_responder
    import sbe_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              load_en_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic [BYTE_W-1:0] load_data_i,
    output logic              sda_o
);
    logic              scl_w;
    logic              sda_w;
    logic              ev_start_w;
    logic              ev_stop_w;
    logic              ev_rise_w;
    logic              ev_steady_w;
    logic [ADDR_W-1:0] rd_addr_w;
    logic [BYTE_W-1:0] rd_data_w;
    phase_e            phase_w;
    logic              ack_w;

    sbe_line_classifier u_classify (
        .scl_prev  (scl_w),
        .sda_prev  (sda_w),
        .scl_now   (scl_i),
        .sda_now   (sda_i),
        .ev_start  (ev_start_w),
        .ev_stop   (ev_stop_w),
        .ev_rise   (ev_rise_w),
        .ev_steady (ev_steady_w)
    );

    sbe_store #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_store (
        .clk     (clk),
        .wr_en   (load_en_i),
        .wr_addr (load_addr_i),
        .wr_data (load_data_i),
        .rd_addr (rd_addr_w),
        .rd_data (rd_data_w)
    );

    sbe_sequencer #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step_i),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .ev_start  (ev_start_w),
        .ev_stop   (ev_stop_w),
        .ev_rise   (ev_rise_w),
        .ev_steady (ev_steady_w),
        .rd_data   (rd_data_w),
        .rd_addr   (rd_addr_w),
        .scl_q_o   (scl_w),
        .sda_q_o   (sda_w),
        .phase_o   (phase_w),
        .ack_o     (ack_w)
    );

    assign sda_o = sda_w;
endmodule

// File: rtl/sbe_checker.sv
`timescale 1ns/1ps
module sbe_checker
    import sbe_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   step_i,
    input logic   scl_i,
    input logic   sda_i,
    input logic   sda_o,
    input phase_e phase,
    input logic   ack,
    input logic   scl_hold
);
    // R10
    no_step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> ($stable(sda_o) && $stable(phase) && $stable(ack)));

    // R5
    ack_drive_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && ack && !scl_hold && scl_i) |=> !sda_o);

    // R9
    follow_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !ack && (phase != PH_ADDR)) |=> (sda_o == $past(sda_i)));

    // R2
    start_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && scl_hold && scl_i && sda_o && !sda_i) |=> (phase == PH_CMD));

    // R4
    cmd_done_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_ADDR) && ($past(phase) == PH_CMD)) |-> ack);

    // R7
    addr_done_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_IDLE) && ($past(phase) == PH_ADDR)) |-> ack);
endmodule

bind sbe_eeprom_responder sbe_checker u_sbe_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_i   (step_i),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_o    (sda_o),
    .phase    (phase_w),
    .ack      (ack_w),
    .scl_hold (scl_w)
);

// File: tb/sbe_eeprom_responder_bench.sv
`timescale 1ns/1ps
module sbe_eeprom_responder_bench;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          step_i = 1'b0;
    logic          scl_i = 1'b1;
    logic          sda_i = 1'b1;
    logic          load_en_i = 1'b0;
    logic [AW-1:0] load_addr_i = '0;
    logic [7:0]    load_data_i = '0;
    logic          sda_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] model [256];

    always #2.5 clk = ~clk;

    sbe_eeprom_responder #(.ADDR_W(AW)) u_sbe_eeprom_responder (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_i      (step_i),
        .scl_i       (scl_i),
        .sda_i       (sda_i),
        .load_en_i   (load_en_i),
        .load_addr_i (load_addr_i),
        .load_data_i (load_data_i),
        .sda_o       (sda_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ev(input logic s, input logic d);
        @(negedge clk);
        step_i = 1'b1;
        scl_i  = s;
        sda_i  = d;
        @(negedge clk);
        step_i = 1'b0;
    endtask

    task automatic bitx(input logic b, output logic seen);
        ev(1'b0, b);
        ev(1'b1, b);
        seen = sda_o;
    endtask

    task automatic start_cond();
        ev(1'b0, 1'b1);
        ev(1'b1, 1'b1);
        ev(1'b1, 1'b0);
    endtask

    task automatic stop_cond();
        ev(1'b0, 1'b0);
        ev(1'b1, 1'b0);
        ev(1'b1, 1'b1);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic [7:0] seen);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bitx(v[i], b);
            seen[i] = b;
        end
    endtask

    task automatic ack_slot(input string tag);
        ev(1'b0, 1'b1);
        ev(1'b1, 1'b1);
        chk(tag, int'(sda_o), 0);
    endtask

    task automatic load(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        load_en_i   = 1'b1;
        load_addr_i = a;
        load_data_i = d;
        model[a]    = d;
        @(negedge clk);
        load_en_i = 1'b0;
    endtask

    // One full frame: start, command, ack, address, ack, stop
    task automatic txn(input logic [7:0] cmd, input logic [7:0] addr,
                       input logic [7:0] exp_out, input string tag);
        logic [7:0] seen;
        start_cond();
        send_byte(cmd, seen);
        chk({tag, " R4 command echo"}, int'(seen), int'(cmd));
        ack_slot({tag, " R5 command ack"});
        send_byte(addr, seen);
        chk({tag, " R6/R11 address-phase output"}, int'(seen), int'(exp_out));
        ack_slot({tag, " R7 address ack"});
        stop_cond();
    endtask

    task automatic t_reset();
        chk("R1 sda_o idle high after reset", int'(sda_o), 1);
        ev(1'b0, 1'b1);
        ev(1'b1, 1'b1);
        chk("R1 rise before any start ignored", int'(sda_o), 1);
        ev(1'b0, 1'b0);
        chk("R9 sda_o follows host low level", int'(sda_o), 0);
        ev(1'b0, 1'b1);
    endtask

    task automatic t_frames();
        txn(8'hA0, 8'h5A, 8'h5A, "write-mode");
        txn(8'hA1, 8'hA5, model[8'h5A], "read 5A");
        txn(8'hA1, 8'hFF, model[8'hA5], "read A5");
        txn(8'hA1, 8'h00, model[8'hFF], "read FF");
        txn(8'hA1, 8'h3C, model[8'h00], "read 00");
    endtask

    task automatic t_idle_ignore();
        logic b;
        logic [7:0] pat;
        pat = 8'hA1;
        for (int i = 7; i >= 0; i--) begin
            bitx(pat[i], b);
            chk("R3 idle rise shows host level", int'(b), int'(pat[i]));
        end
        stop_cond();
        ev(1'b1, 1'b0);
        ev(1'b0, 1'b0);
        ev(1'b1, 1'b1);
        txn(8'hA1, 8'h5A, model[8'h3C], "R3 data kept through idle");
    endtask

    task automatic t_no_step();
        logic [7:0] seen;
        logic b;
        start_cond();
        bitx(1'b1, b);
        bitx(1'b0, b);
        bitx(1'b1, b);
        bitx(1'b0, b);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            scl_i = k[0];
            sda_i = k[1];
        end
        @(negedge clk);
        chk("R10 sda_o unchanged without step", int'(sda_o), 0);
        bitx(1'b0, b);
        bitx(1'b0, b);
        bitx(1'b0, b);
        bitx(1'b1, b);
        chk("R10 eighth bit after idle cycles is host level", int'(b), 1);
        ack_slot("R10 ack position unchanged");
        send_byte(8'h00, seen);
        chk("R10 read data after pause", int'(seen), int'(model[8'h5A]));
        ack_slot("R10 address ack");
        stop_cond();
    endtask

    task automatic t_glitch();
        logic [7:0] seen;
        logic b;
        logic [6:0] pre;
        start_cond();
        pre = 7'b1010000;
        for (int i = 6; i >= 0; i--) begin
            bitx(pre[i], b);
        end
        ev(1'b0, 1'b0);
        ev(1'b1, 1'b1);
        chk("R8 glitched rise leaves host level", int'(sda_o), 1);
        bitx(1'b1, b);
        chk("R8 eighth real bit not taken as ack", int'(b), 1);
        ack_slot("R8 ack after eight real bits");
        send_byte(8'hFF, seen);
        chk("R8 read data after glitch", int'(seen), int'(model[8'h00]));
        ack_slot("R8 address ack");
        stop_cond();
    endtask

    task automatic t_stop_mid();
        logic [7:0] seen;
        logic b;
        logic [5:0] rest;
        start_cond();
        bitx(1'b1, b);
        bitx(1'b0, b);
        ev(1'b1, 1'b1);
        chk("R2 stop mid-byte keeps host level", int'(sda_o), 1);
        rest = 6'b100001;
        for (int i = 5; i >= 0; i--) begin
            bitx(rest[i], b);
        end
        chk("R2 last bit after stop is host level", int'(b), 1);
        ack_slot("R2 ack position after mid-byte stop");
        send_byte(8'hA5, seen);
        chk("R2 read data after mid-byte stop", int'(seen), int'(model[8'hFF]));
        ack_slot("R2 address ack");
        stop_cond();
    endtask

    task automatic t_start_in_ack();
        logic [7:0] seen;
        start_cond();
        send_byte(8'hA1, seen);
        ev(1'b1, 1'b0);
        ack_slot("R2 pending ack survives restart");
        send_byte(8'hA1, seen);
        chk("R2 command echo after restart", int'(seen), 8'hA1);
        ack_slot("R5 ack after restarted command");
        send_byte(8'h5A, seen);
        chk("R6 read data after restart", int'(seen), int'(model[8'hA5]));
        ack_slot("R7 address ack after restart");
        stop_cond();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        load(8'h5A, 8'hC3);
        load(8'hA5, 8'h96);
        load(8'hFF, 8'h81);
        load(8'h00, 8'h7E);
        load(8'h3C, 8'h35);
        t_frames();
        t_idle_ignore();
        t_no_step();
        t_glitch();
        t_stop_mid();
        t_start_in_ack();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule